// File: doc/BRIEF.md
# Band-Selectable Reference Divider with Three-State Phase Comparator

This block sits in a frequency synthesizer loop. It turns a crystal clock into a low-rate comparison reference and compares that reference against the divided-down oscillator pulse coming back from the loop counter. The crystal clock first passes through a fixed divide-by-4 stage. A second stage then divides by 520 or by 624, depending on a band select input. With a 10.4 MHz crystal this gives a reference of about 5 kHz on the VHF bands and about 4.167 kHz on UHF.

The comparator holds one flag for each input. A rising edge on an input sets its flag. When both flags are set, both are cleared together. The output drives only while exactly one flag is set. The drive enable together with the drive level stands in for a three-state pin.
- If the reference edge arrives first, the loop oscillator is slow and the output pulls low.
- If the loop edge arrives first, the oscillator is fast and the output pulls high.
- If both edges fall in the same cycle, the output stays undriven.

A change of band restarts the divider chain and drops any pending correction, so no partial period is produced. A lock indication reports when the loop has stayed close to the reference for several periods in a row.

Top module: `refpd_top`

## Requirements
- R1: While `rst_n` is low, `ref_tick`, `pd_drive`, `pd_level` and `lock` are all 0.
- R2: With `uhf_sel` = 0 and the band steady, `ref_tick` is a one-cycle pulse repeating every 2080 clock cycles (4 × 520).
- R3: With `uhf_sel` = 1 and the band steady, `ref_tick` repeats every 2496 clock cycles (4 × 624).
- R4: A reference pulse that arrives with no pending loop edge turns on `pd_drive` with `pd_level` = 0 (pull down: loop slow) from the next cycle.
- R5: A rising edge of `fb_pulse` that arrives with no pending reference pulse turns on `pd_drive` with `pd_level` = 1 (pull up: loop fast) from the next cycle.
- R6: A reference pulse and a `fb_pulse` rising edge in the same cycle leave `pd_drive` at 0.
- R7: `pd_drive` stays on for exactly as many clock cycles as separate the two events, and `pd_level` does not change while it is on. Only the rising edge of `fb_pulse` counts.
- R8: A change of `uhf_sel` clears `pd_drive` from the next cycle. The first `ref_tick` under the new band comes 4·N clock edges after the edge that samples the change, with N = 520 or 624.
- R9: `lock` rises after the 8th consecutive reference period in which no `pd_drive` run lasted more than 2 cycles. It becomes visible right after the clock edge that registers that reference pulse.
- R10: A reference period that contains a `pd_drive` run of 3 or more cycles clears `lock` after its closing reference pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| xtal_clk | input | 1 | Crystal clock; all logic runs on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| uhf_sel | input | 1 | Band select: 0 selects divide-by-520, 1 selects divide-by-624 |
| fb_pulse | input | 1 | Divided loop-oscillator signal; its rising edges are compared |
| ref_tick | output | 1 | One-cycle reference pulse at the end of each reference period |
| pd_level | output | 1 | Comparator drive level: 0 pulls down, 1 pulls up; meaningful when `pd_drive` is 1 |
| pd_drive | output | 1 | Comparator drive enable; 0 means high impedance |
| lock | output | 1 | Loop judged close to the reference for 8 consecutive periods |

## Verification
The assertions assume the following about the inputs:
- `fb_pulse` is already synchronous to the crystal clock.
- `uhf_sel` changes only between clock edges.
- Loop edges come at most about once per reference period, so the two comparator flags never need to queue a second event.

The stimulus respects these assumptions:
- Every input changes on the falling clock edge.
- `fb_pulse` is raised for a single cycle, at a position counted from the last observed `ref_tick`.
- Each phase offset is set up only after the two inputs have first been brought into phase.
- Band changes are made with the loop input idle.

// File: rtl/refpd_pkg.sv
package refpd_pkg;

  localparam int unsigned PRE_DIV_DEF  = 4;
  localparam int unsigned VHF_DIV_DEF  = 520;
  localparam int unsigned UHF_DIV_DEF  = 624;
  localparam int unsigned LOCK_PER_DEF = 8;
  localparam int unsigned MAX_RUN_DEF  = 2;

  typedef enum logic {
    PD_PULL_DOWN = 1'b0,
    PD_PULL_UP   = 1'b1
  } pd_dir_e;

  typedef struct packed {
    logic ref_seen;
    logic fb_seen;
  } pfd_flags_t;

endpackage

// File: rtl/refpd_prescale.sv
module refpd_prescale #(
  parameter int unsigned PRE_DIV = refpd_pkg::PRE_DIV_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic ce_o
);

  generate
    if (PRE_DIV <= 1) begin : g_bypass
      assign ce_o = 1'b1;
    end else begin : g_count
      localparam int unsigned PW = $clog2(PRE_DIV);
      localparam logic [PW-1:0] LAST = PW'(PRE_DIV - 1);

      logic [PW-1:0] cnt_q, cnt_d;

      always_comb begin
        cnt_d = cnt_q;
        if (clr)                cnt_d = '0;
        else if (cnt_q == LAST) cnt_d = '0;
        else                    cnt_d = cnt_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end

      assign ce_o = (cnt_q == LAST);

      a_r2_ce_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        ce_o |=> !ce_o);
    end
  endgenerate

endmodule

// File: rtl/refpd_banddiv.sv
module refpd_banddiv #(
  parameter int unsigned VHF_DIV = refpd_pkg::VHF_DIV_DEF,
  parameter int unsigned UHF_DIV = refpd_pkg::UHF_DIV_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic ce_i,
  input  logic uhf_i,
  output logic tick_o
);

  localparam int unsigned MAXD  = (VHF_DIV > UHF_DIV) ? VHF_DIV : UHF_DIV;
  localparam int unsigned CW    = $clog2(MAXD);
  localparam logic [CW-1:0] LIM_V = CW'(VHF_DIV - 1);
  localparam logic [CW-1:0] LIM_U = CW'(UHF_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d, lim;
  logic          tick_q, tick_d, wrap;

  always_comb begin
    lim    = uhf_i ? LIM_U : LIM_V;
    wrap   = ce_i && (cnt_q == lim);
    cnt_d  = cnt_q;
    if (clr)       cnt_d = '0;
    else if (wrap) cnt_d = '0;
    else if (ce_i) cnt_d = cnt_q + 1'b1;
    tick_d = wrap && !clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign tick_o = tick_q;

  a_r2_tick_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);
  a_r3_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= lim);
  a_r8_clr_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0 && !tick_o));

endmodule

// File: rtl/refpd_pfd.sv
module refpd_pfd (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic ref_ev,
  input  logic fb_ev,
  output logic drive_o,
  output logic level_o
);

  import refpd_pkg::*;

  pfd_flags_t flg_q, flg_d, flg_set;

  always_comb begin
    flg_set.ref_seen = flg_q.ref_seen | ref_ev;
    flg_set.fb_seen  = flg_q.fb_seen  | fb_ev;
    flg_d            = flg_set;
    if (clr || (flg_set.ref_seen && flg_set.fb_seen)) flg_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flg_q <= '0;
    else        flg_q <= flg_d;
  end

  assign drive_o = flg_q.ref_seen ^ flg_q.fb_seen;
  assign level_o = flg_q.fb_seen ? PD_PULL_UP : PD_PULL_DOWN;

  a_r4_ref_first_pulls_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && ref_ev && !fb_ev && !drive_o) |=> (drive_o && !level_o));
  a_r5_fb_first_pulls_up: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && fb_ev && !ref_ev && !drive_o) |=> (drive_o && level_o));
  a_r6_coincident_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_ev && fb_ev && !drive_o) |=> !drive_o);
  a_r7_hold_until_other: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_o && !ref_ev && !fb_ev && !clr) |=> (drive_o && $stable(level_o)));
  a_r8_band_clears_drive: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !drive_o);

endmodule

// File: rtl/refpd_lock.sv
module refpd_lock #(
  parameter int unsigned LOCK_PERIODS = refpd_pkg::LOCK_PER_DEF,
  parameter int unsigned MAX_RUN      = refpd_pkg::MAX_RUN_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic ref_ev,
  input  logic drive_i,
  output logic lock_o
);

  localparam int unsigned GCW = $clog2(LOCK_PERIODS + 1);
  localparam int unsigned RCW = $clog2(MAX_RUN + 2);
  localparam logic [GCW-1:0] GOAL  = GCW'(LOCK_PERIODS);
  localparam logic [RCW-1:0] LIMIT = RCW'(MAX_RUN);

  logic [RCW-1:0] run_q, run_d;
  logic [GCW-1:0] good_q, good_d;
  logic           bad_q, bad_d, over, period_bad;

  always_comb begin
    over       = drive_i && (run_q >= LIMIT);
    period_bad = bad_q || over;

    run_d = run_q;
    if (!drive_i || clr)  run_d = '0;
    else if (!over)       run_d = run_q + 1'b1;

    bad_d = bad_q;
    if (clr || ref_ev)    bad_d = 1'b0;
    else if (over)        bad_d = 1'b1;

    good_d = good_q;
    if (clr)                   good_d = '0;
    else if (ref_ev) begin
      if (period_bad)          good_d = '0;
      else if (good_q != GOAL) good_d = good_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      bad_q  <= 1'b0;
      good_q <= '0;
    end else begin
      run_q  <= run_d;
      bad_q  <= bad_d;
      good_q <= good_d;
    end
  end

  assign lock_o = (good_q == GOAL);

  a_r9_lock_rises_on_ref: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_o) |-> $past(ref_ev));
  a_r10_long_run_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_ev && over && !clr) |=> !lock_o);
  a_r8_band_drops_lock: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !lock_o);

endmodule

// File: rtl/refpd_top.sv
module refpd_top #(
  parameter int unsigned PRE_DIV      = refpd_pkg::PRE_DIV_DEF,
  parameter int unsigned VHF_DIV      = refpd_pkg::VHF_DIV_DEF,
  parameter int unsigned UHF_DIV      = refpd_pkg::UHF_DIV_DEF,
  parameter int unsigned LOCK_PERIODS = refpd_pkg::LOCK_PER_DEF,
  parameter int unsigned MAX_RUN      = refpd_pkg::MAX_RUN_DEF
) (
  input  logic xtal_clk,
  input  logic rst_n,
  input  logic uhf_sel,
  input  logic fb_pulse,
  output logic ref_tick,
  output logic pd_level,
  output logic pd_drive,
  output logic lock
);

  logic [1:0] rst_pipe_q;
  logic       core_rst_n;
  logic       band_q, band_d, fb_q, fb_d;
  logic       band_chg, fb_rise, pre_ce, tick;

  always_ff @(posedge xtal_clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign core_rst_n = rst_pipe_q[1];

  always_comb begin
    band_d   = uhf_sel;
    fb_d     = fb_pulse;
    band_chg = (uhf_sel != band_q);
    fb_rise  = fb_pulse && !fb_q;
  end

  always_ff @(posedge xtal_clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      band_q <= 1'b0;
      fb_q   <= 1'b0;
    end else begin
      band_q <= band_d;
      fb_q   <= fb_d;
    end
  end

  refpd_prescale #(.PRE_DIV(PRE_DIV)) u_pre (
    .clk(xtal_clk), .rst_n(core_rst_n), .clr(band_chg), .ce_o(pre_ce)
  );

  refpd_banddiv #(.VHF_DIV(VHF_DIV), .UHF_DIV(UHF_DIV)) u_div (
    .clk(xtal_clk), .rst_n(core_rst_n), .clr(band_chg), .ce_i(pre_ce),
    .uhf_i(band_q), .tick_o(tick)
  );

  refpd_pfd u_pfd (
    .clk(xtal_clk), .rst_n(core_rst_n), .clr(band_chg), .ref_ev(tick),
    .fb_ev(fb_rise), .drive_o(pd_drive), .level_o(pd_level)
  );

  refpd_lock #(.LOCK_PERIODS(LOCK_PERIODS), .MAX_RUN(MAX_RUN)) u_lock (
    .clk(xtal_clk), .rst_n(core_rst_n), .clr(band_chg), .ref_ev(tick),
    .drive_i(pd_drive), .lock_o(lock)
  );

  assign ref_tick = tick;

  a_r1_quiet_in_reset: assert property (@(posedge xtal_clk)
    !core_rst_n |-> (!ref_tick && !pd_drive && !lock));
  a_r7_rise_only: assert property (@(posedge xtal_clk) disable iff (!core_rst_n)
    (fb_q && fb_pulse && !tick && !band_chg && !pd_drive) |=> !pd_drive);

endmodule

// File: tb/refpd_top_tb.sv
module refpd_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int P_VHF      = 4 * 520;
  localparam int P_UHF      = 4 * 624;

  typedef struct packed {
    bit uhf;
    bit lead_fb;
    int k;
    int exp_w;
    int exp_hi;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{1'b0, 1'b0, 1,  1,  0},
    '{1'b0, 1'b0, 4,  4,  0},
    '{1'b0, 1'b0, 10, 10, 0},
    '{1'b0, 1'b0, 0,  0,  0},
    '{1'b0, 1'b1, 1,  1,  1},
    '{1'b0, 1'b1, 5,  5,  5},
    '{1'b0, 1'b1, 12, 12, 12},
    '{1'b1, 1'b0, 6,  6,  0},
    '{1'b1, 1'b1, 3,  3,  3}
  };

  logic clk = 1'b0;
  logic rst_n, uhf_sel, fb_pulse;
  logic ref_tick, pd_level, pd_drive, lock;
  int   n_checks = 0;
  int   n_errors = 0;
  int   drv_cnt, hi_cnt;

  always #(CLK_PERIOD / 2) clk = ~clk;

  refpd_top dut_i (
    .xtal_clk(clk), .rst_n(rst_n), .uhf_sel(uhf_sel), .fb_pulse(fb_pulse),
    .ref_tick(ref_tick), .pd_level(pd_level), .pd_drive(pd_drive), .lock(lock)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (pd_drive) drv_cnt++;
    if (pd_drive && pd_level) hi_cnt++;
  endtask

  task automatic wait_ref();
    do step(); while (!ref_tick);
  endtask

  task automatic run_vec(input bit lead_fb, input int k, input int per);
    wait_ref();
    fb_pulse = 1'b1;
    step();
    fb_pulse = 1'b0;
    drv_cnt = 0;
    hi_cnt  = 0;
    if (lead_fb) begin
      repeat (per - k - 1) step();
    end else begin
      wait_ref();
      repeat (k) step();
    end
    fb_pulse = 1'b1;
    step();
    fb_pulse = 1'b0;
    repeat (20) step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    int c;
    rst_n = 1'b0; uhf_sel = 1'b0; fb_pulse = 1'b0;
    drv_cnt = 0; hi_cnt = 0;
    repeat (3) step();
    chk("R1 ref_tick", int'(ref_tick), 0);
    chk("R1 pd_drive", int'(pd_drive), 0);
    chk("R1 pd_level", int'(pd_level), 0);
    chk("R1 lock", int'(lock), 0);
    rst_n = 1'b1;

    // R2: VHF period
    wait_ref();
    c = 0;
    do begin step(); c++; end while (!ref_tick);
    chk("R2 vhf period", c, P_VHF);

    // R8 / R4: pending pull-down cleared by band change, divider restart
    wait_ref();
    repeat (3) step();
    chk("R4 pending drive", int'(pd_drive), 1);
    chk("R4 pending level", int'(pd_level), 0);
    uhf_sel = 1'b1;
    step();
    chk("R8 drive cleared", int'(pd_drive), 0);
    c = 1;
    while (!ref_tick) begin step(); c++; end
    chk("R8 first uhf tick", c, P_UHF + 1);
    c = 0;
    do begin step(); c++; end while (!ref_tick);
    chk("R3 uhf period", c, P_UHF);
    uhf_sel = 1'b0;
    step();

    // R4-R7: phase offset table
    foreach (VECS[i]) begin
      if (uhf_sel != VECS[i].uhf) begin
        uhf_sel = VECS[i].uhf;
        step();
      end
      run_vec(VECS[i].lead_fb, VECS[i].k, VECS[i].uhf ? P_UHF : P_VHF);
      chk(VECS[i].exp_w == 0 ? "R6 in-phase width" : "R7 drive width", drv_cnt, VECS[i].exp_w);
      chk(VECS[i].lead_fb ? "R5 pull-up cycles" : "R4 pull-up cycles", hi_cnt, VECS[i].exp_hi);
    end

    // R9 / R10: lock qualification
    rst_n = 1'b0; uhf_sel = 1'b0; fb_pulse = 1'b0;
    repeat (2) step();
    rst_n = 1'b1;
    for (int i = 1; i <= 9; i++) begin
      wait_ref();
      fb_pulse = 1'b1;
      step();
      fb_pulse = 1'b0;
      chk($sformatf("R9 lock after %0d periods", i), int'(lock), (i >= 8) ? 1 : 0);
    end
    run_vec(1'b1, 2, P_VHF);
    chk("R9 lock kept with 2-cycle run", int'(lock), 1);
    run_vec(1'b1, 3, P_VHF);
    chk("R10 lock dropped by 3-cycle run", int'(lock), 0);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule